// File: doc/BRIEF.md
# Batched GF(2^8) Packet Combiner

This block builds coded packets for a network-coding encoder. It forms each output byte as a sum of products over GF(2^8). Source packets live in a byte store and are reached indirectly: a packet-number table names which stored packet supplies each term. Every byte of that packet is multiplied by a coefficient taken from a coefficient memory, and the products are summed with XOR. The work is split into batches. Each batch has its own degree, which is the number of source terms it uses. Batches may differ in size, so the region of the index and coefficient tables that a batch uses begins where the previous batch's region ended.

A single `start` pulse runs the whole job. The block reads each batch's degree, then walks the coded packets of that batch and the byte positions of each packet. It issues one term per clock through a fixed read pipeline and writes every result byte once to a result memory. A one-cycle `done` pulse ends the job. All read ports are simple synchronous memories that return data one clock after the address.

Top module: `gfc_combiner`

## Requirements
- R1: Field multiplication runs eight shift-and-add steps. In each step the multiplicand is XORed into the product when bit 0 of the multiplier is 1. The multiplicand then shifts left by one, and if its bit 7 was 1 before the shift it is XORed with 0x1D (the polynomial 0x11D). The multiplier shifts right by one. Examples: 0x80·0x02 = 0x1D and 0x80·0x03 = 0x9D.
- R2: Each output byte is the XOR of its term products, and the sum restarts from zero for every output byte.
- R3: The term k source byte for byte position m is read from the packet store at P·PKT_LEN + m. P is the 8-bit packet number read from the index table at (batch offset + k).
- R4: The offset of batch b is the sum of the degree-table entries of batches 0 to b-1. The offset of batch 0 is zero.
- R5: The coefficient for term k and coded packet n is read at ((batch offset + k)·CODED_N + n).
- R6: A batch uses floor(degree / TILE_K)·TILE_K terms. Terms beyond that are ignored, and a batch with no usable term writes 0x00 to all of its bytes.
- R7: The result for batch b, coded packet n and byte m is written once at (b·CODED_N + n)·PKT_LEN + m. Writes occur in increasing address order and only while `busy` is high.
- R8: `busy` rises the cycle after an accepted `start`. `done` is high for exactly one cycle, in the cycle after the last result write, with `busy` already low.
- R9: A `start` pulse while `busy` is high is ignored. The job completes with exactly PKT_LEN·CODED_N·NUM_BATCH writes and a single `done`.
- R10: The block issues one term per clock. Inside a batch with T > 0 usable terms, consecutive result writes are exactly T cycles apart. A change of batch adds two cycles for the degree read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a job when idle |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| deg_addr | output | $clog2(NUM_BATCH) | Degree table read address |
| deg_data | input | 8 | Degree table read data (one-cycle latency) |
| idx_addr | output | IDX_AW | Packet-number table read address |
| idx_data | input | 8 | Packet number read data |
| coef_addr | output | COEF_AW | Coefficient memory read address |
| coef_data | input | 8 | Coefficient read data |
| pkt_addr | output | 8+$clog2(PKT_LEN) | Packet store byte address |
| pkt_data | input | 8 | Packet store read data |
| res_we | output | 1 | Result write strobe |
| res_addr | output | $clog2(PKT_LEN·CODED_N·NUM_BATCH) | Result write address |
| res_data | output | 8 | Result byte |

## Verification
The first patterns fill every stored byte with 0x80 and alternate the coefficients between 0x02 and zero, then between 0x03 and zero. Every output then has one known value, which separates a wrong reduction constant or a wrong bit order from a wrong summation. Random packets, packet numbers and coefficients with equal degrees of four test the indirect gather, the coefficient addressing and the XOR accumulation against an independent model. The same run checks the write spacing that shows one term per clock. Uneven degrees of 3, 0, 6 and 1 shift every later batch's offset, cut off partial tiles and force all-zero batches. A final run places an extra start pulse in the middle of the job and checks the timing of done against the last write.

// File: rtl/gfc_pkg.sv
package gfc_pkg;

  // Low byte of the field polynomial x^8+x^4+x^3+x^2+1; bit 8 shifts out.
  localparam logic [7:0] GF_RED = 8'h1D;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DREQ,
    ST_DLAT,
    ST_RUN,
    ST_DRAIN
  } ctl_state_t;

endpackage

// File: rtl/gfc_gf_mul.sv
module gfc_gf_mul
  import gfc_pkg::*;
(
  input  logic [7:0] mcand,
  input  logic [7:0] mplier,
  output logic [7:0] prod
);

  // Eight unrolled shift-and-add stages.
  always_comb begin
    logic [7:0] a_v;
    logic [7:0] b_v;
    logic [7:0] p_v;
    a_v = mcand;
    b_v = mplier;
    p_v = 8'h00;
    for (int i = 0; i < 8; i++) begin
      if (b_v[0]) p_v = p_v ^ a_v;
      if (a_v[7]) a_v = {a_v[6:0], 1'b0} ^ GF_RED;
      else        a_v = {a_v[6:0], 1'b0};
      b_v = {1'b0, b_v[7:1]};
    end
    prod = p_v;
  end

endmodule

// File: rtl/gfc_ctrl.sv
module gfc_ctrl
  import gfc_pkg::*;
#(
  parameter  int PKT_LEN   = 16,
  parameter  int CODED_N   = 4,
  parameter  int TILE_K    = 2,
  parameter  int NUM_BATCH = 4,
  parameter  int IDX_AW    = 8,
  parameter  int COEF_AW   = 10,
  localparam int PKT_W     = $clog2(PKT_LEN),
  localparam int CN_W      = $clog2(CODED_N),
  localparam int NB_W      = $clog2(NUM_BATCH),
  localparam int RES_AW    = $clog2(PKT_LEN * CODED_N * NUM_BATCH),
  localparam int OFF_W     = NB_W + 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        deg_data,
  input  logic              pipe_busy,
  output logic              busy,
  output logic              done,
  output logic [NB_W-1:0]   deg_addr,
  output logic [IDX_AW-1:0] idx_addr,
  output logic [COEF_AW-1:0] coef_addr,
  output logic              iss_valid,
  output logic              iss_term,
  output logic              iss_first,
  output logic              iss_last,
  output logic [PKT_W-1:0]  iss_pos,
  output logic [RES_AW-1:0] iss_res
);

  localparam int CL_W = OFF_W + CN_W + 1;
  localparam logic [PKT_W-1:0] M_LAST = PKT_W'(PKT_LEN - 1);
  localparam logic [CN_W-1:0]  N_LAST = CN_W'(CODED_N - 1);
  localparam logic [NB_W-1:0]  B_LAST = NB_W'(NUM_BATCH - 1);

  ctl_state_t          state_q, state_d;
  logic [NB_W-1:0]     bat_q, bat_d;
  logic [OFF_W-1:0]    off_q, off_d;
  logic [7:0]          deg_q, deg_d;
  logic [7:0]          terms_q, terms_d;
  logic [7:0]          k_q, k_d;
  logic [PKT_W-1:0]    m_q, m_d;
  logic [CN_W-1:0]     n_q, n_d;
  logic [RES_AW-1:0]   res_q, res_d;
  logic                done_q, done_d;
  logic [IDX_AW-1:0]   idx_q, idx_d;
  logic [COEF_AW-1:0]  coef_q, coef_d;
  logic                iv_q, iv_d, it_q, it_d, if_q, if_d, il_q, il_d;
  logic [PKT_W-1:0]    ip_q, ip_d;
  logic [RES_AW-1:0]   ir_q, ir_d;

  logic [7:0]          kmax;
  logic [OFF_W-1:0]    term_idx;
  logic [CL_W-1:0]     coef_lin;

  assign kmax     = (terms_q == 8'd0) ? 8'd0 : terms_q - 8'd1;
  assign term_idx = off_q + OFF_W'(k_q);
  assign coef_lin = CL_W'(term_idx) * CL_W'(CODED_N) + CL_W'(n_q);

  // Next-state logic
  always_comb begin
    state_d = state_q;
    bat_d   = bat_q;
    off_d   = off_q;
    deg_d   = deg_q;
    terms_d = terms_q;
    k_d     = k_q;
    m_d     = m_q;
    n_d     = n_q;
    res_d   = res_q;
    done_d  = 1'b0;
    idx_d   = idx_q;
    coef_d  = coef_q;
    iv_d    = 1'b0;
    it_d    = it_q;
    if_d    = if_q;
    il_d    = il_q;
    ip_d    = ip_q;
    ir_d    = ir_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_DREQ;
          bat_d   = '0;
          off_d   = '0;
          res_d   = '0;
        end
      end
      ST_DREQ: state_d = ST_DLAT;
      ST_DLAT: begin
        deg_d   = deg_data;
        terms_d = 8'((int'(deg_data) / TILE_K) * TILE_K);
        k_d     = '0;
        m_d     = '0;
        n_d     = '0;
        state_d = ST_RUN;
      end
      ST_RUN: begin
        iv_d   = 1'b1;
        it_d   = (terms_q != 8'd0);
        if_d   = (k_q == 8'd0);
        il_d   = (k_q == kmax);
        ip_d   = m_q;
        ir_d   = res_q;
        idx_d  = IDX_AW'(term_idx);
        coef_d = COEF_AW'(coef_lin);
        if (k_q == kmax) begin
          k_d   = '0;
          res_d = res_q + 1'b1;
          if (m_q == M_LAST) begin
            m_d = '0;
            if (n_q == N_LAST) begin
              n_d   = '0;
              off_d = off_q + OFF_W'(deg_q);
              if (bat_q == B_LAST) begin
                state_d = ST_DRAIN;
              end else begin
                bat_d   = bat_q + 1'b1;
                state_d = ST_DREQ;
              end
            end else begin
              n_d = n_q + 1'b1;
            end
          end else begin
            m_d = m_q + 1'b1;
          end
        end else begin
          k_d = k_q + 8'd1;
        end
      end
      ST_DRAIN: begin
        if (!pipe_busy && !iv_q) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bat_q   <= '0;
      off_q   <= '0;
      deg_q   <= '0;
      terms_q <= '0;
      k_q     <= '0;
      m_q     <= '0;
      n_q     <= '0;
      res_q   <= '0;
      done_q  <= 1'b0;
      idx_q   <= '0;
      coef_q  <= '0;
      iv_q    <= 1'b0;
      it_q    <= 1'b0;
      if_q    <= 1'b0;
      il_q    <= 1'b0;
      ip_q    <= '0;
      ir_q    <= '0;
    end else begin
      state_q <= state_d;
      bat_q   <= bat_d;
      off_q   <= off_d;
      deg_q   <= deg_d;
      terms_q <= terms_d;
      k_q     <= k_d;
      m_q     <= m_d;
      n_q     <= n_d;
      res_q   <= res_d;
      done_q  <= done_d;
      iv_q    <= iv_d;
      if (iv_d) begin
        idx_q  <= idx_d;
        coef_q <= coef_d;
        it_q   <= it_d;
        if_q   <= if_d;
        il_q   <= il_d;
        ip_q   <= ip_d;
        ir_q   <= ir_d;
      end
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign deg_addr  = bat_q;
  assign idx_addr  = idx_q;
  assign coef_addr = coef_q;
  assign iss_valid = iv_q;
  assign iss_term  = it_q;
  assign iss_first = if_q;
  assign iss_last  = il_q;
  assign iss_pos   = ip_q;
  assign iss_res   = ir_q;

endmodule

// File: rtl/gfc_gather.sv
module gfc_gather #(
  parameter  int PKT_LEN   = 16,
  parameter  int CODED_N   = 4,
  parameter  int NUM_BATCH = 4,
  localparam int PKT_W     = $clog2(PKT_LEN),
  localparam int PKT_AW    = 8 + PKT_W,
  localparam int RES_AW    = $clog2(PKT_LEN * CODED_N * NUM_BATCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic              iss_term,
  input  logic              iss_first,
  input  logic              iss_last,
  input  logic [PKT_W-1:0]  iss_pos,
  input  logic [RES_AW-1:0] iss_res,
  input  logic [7:0]        idx_data,
  input  logic [7:0]        coef_data,
  input  logic [7:0]        pkt_data,
  output logic [PKT_AW-1:0] pkt_addr,
  output logic              pipe_busy,
  output logic              res_we,
  output logic [RES_AW-1:0] res_addr,
  output logic [7:0]        res_data
);

  // Stage 2: packet number and coefficient arrive.
  logic              s2_v_q, s2_t_q, s2_f_q, s2_l_q;
  logic [PKT_W-1:0]  s2_pos_q;
  logic [RES_AW-1:0] s2_res_q;
  // Stage 3: source byte arrives, multiply and accumulate.
  logic              s3_v_q, s3_t_q, s3_f_q, s3_l_q;
  logic [RES_AW-1:0] s3_res_q;
  logic [7:0]        s3_coef_q;
  logic [7:0]        acc_q;
  logic              we_q;
  logic [RES_AW-1:0] waddr_q;
  logic [7:0]        wdata_q;

  logic [7:0]        prod;
  logic [7:0]        term_val;
  logic [7:0]        sum_d;

  assign pkt_addr = PKT_AW'(idx_data) * PKT_AW'(PKT_LEN) + PKT_AW'(s2_pos_q);

  gfc_gf_mul u_mul (
    .mcand (pkt_data),
    .mplier(s3_coef_q),
    .prod  (prod)
  );

  always_comb begin
    term_val = s3_t_q ? prod : 8'h00;
    sum_d    = term_val ^ (s3_f_q ? 8'h00 : acc_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_v_q    <= 1'b0;
      s2_t_q    <= 1'b0;
      s2_f_q    <= 1'b0;
      s2_l_q    <= 1'b0;
      s2_pos_q  <= '0;
      s2_res_q  <= '0;
      s3_v_q    <= 1'b0;
      s3_t_q    <= 1'b0;
      s3_f_q    <= 1'b0;
      s3_l_q    <= 1'b0;
      s3_res_q  <= '0;
      s3_coef_q <= '0;
      acc_q     <= '0;
      we_q      <= 1'b0;
      waddr_q   <= '0;
      wdata_q   <= '0;
    end else begin
      s2_v_q <= iss_valid;
      if (iss_valid) begin
        s2_t_q   <= iss_term;
        s2_f_q   <= iss_first;
        s2_l_q   <= iss_last;
        s2_pos_q <= iss_pos;
        s2_res_q <= iss_res;
      end
      s3_v_q <= s2_v_q;
      if (s2_v_q) begin
        s3_t_q    <= s2_t_q;
        s3_f_q    <= s2_f_q;
        s3_l_q    <= s2_l_q;
        s3_res_q  <= s2_res_q;
        s3_coef_q <= coef_data;
      end
      if (s3_v_q) acc_q <= sum_d;
      we_q <= s3_v_q && s3_l_q;
      if (s3_v_q && s3_l_q) begin
        waddr_q <= s3_res_q;
        wdata_q <= sum_d;
      end
    end
  end

  assign pipe_busy = s2_v_q | s3_v_q;
  assign res_we    = we_q;
  assign res_addr  = waddr_q;
  assign res_data  = wdata_q;

endmodule

// File: rtl/gfc_combiner.sv
module gfc_combiner #(
  parameter  int PKT_LEN   = 16,
  parameter  int CODED_N   = 4,
  parameter  int TILE_K    = 2,
  parameter  int NUM_BATCH = 4,
  parameter  int IDX_AW    = 8,
  parameter  int COEF_AW   = 10,
  localparam int PKT_W     = $clog2(PKT_LEN),
  localparam int NB_W      = $clog2(NUM_BATCH),
  localparam int PKT_AW    = 8 + PKT_W,
  localparam int RES_AW    = $clog2(PKT_LEN * CODED_N * NUM_BATCH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  output logic               busy,
  output logic               done,
  output logic [NB_W-1:0]    deg_addr,
  input  logic [7:0]         deg_data,
  output logic [IDX_AW-1:0]  idx_addr,
  input  logic [7:0]         idx_data,
  output logic [COEF_AW-1:0] coef_addr,
  input  logic [7:0]         coef_data,
  output logic [PKT_AW-1:0]  pkt_addr,
  input  logic [7:0]         pkt_data,
  output logic               res_we,
  output logic [RES_AW-1:0]  res_addr,
  output logic [7:0]         res_data
);

  // Reset asserts asynchronously and releases on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic              pipe_busy;
  logic              iss_valid, iss_term, iss_first, iss_last;
  logic [PKT_W-1:0]  iss_pos;
  logic [RES_AW-1:0] iss_res;

  gfc_ctrl #(
    .PKT_LEN  (PKT_LEN),
    .CODED_N  (CODED_N),
    .TILE_K   (TILE_K),
    .NUM_BATCH(NUM_BATCH),
    .IDX_AW   (IDX_AW),
    .COEF_AW  (COEF_AW)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start    (start),
    .deg_data (deg_data),
    .pipe_busy(pipe_busy),
    .busy     (busy),
    .done     (done),
    .deg_addr (deg_addr),
    .idx_addr (idx_addr),
    .coef_addr(coef_addr),
    .iss_valid(iss_valid),
    .iss_term (iss_term),
    .iss_first(iss_first),
    .iss_last (iss_last),
    .iss_pos  (iss_pos),
    .iss_res  (iss_res)
  );

  gfc_gather #(
    .PKT_LEN  (PKT_LEN),
    .CODED_N  (CODED_N),
    .NUM_BATCH(NUM_BATCH)
  ) u_gather (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .iss_valid(iss_valid),
    .iss_term (iss_term),
    .iss_first(iss_first),
    .iss_last (iss_last),
    .iss_pos  (iss_pos),
    .iss_res  (iss_res),
    .idx_data (idx_data),
    .coef_data(coef_data),
    .pkt_data (pkt_data),
    .pkt_addr (pkt_addr),
    .pipe_busy(pipe_busy),
    .res_we   (res_we),
    .res_addr (res_addr),
    .res_data (res_data)
  );

endmodule

// File: rtl/gfc_combiner_sva.sv
module gfc_combiner_sva #(
  parameter  int PKT_LEN   = 16,
  parameter  int CODED_N   = 4,
  parameter  int NUM_BATCH = 4,
  localparam int TOTAL     = PKT_LEN * CODED_N * NUM_BATCH,
  localparam int RES_AW    = $clog2(TOTAL)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              res_we,
  input logic [RES_AW-1:0] res_addr
);

  // Writes seen since the last accepted start.
  logic [RES_AW:0] wr_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                wr_cnt_q <= '0;
    else if (start && !busy)   wr_cnt_q <= '0;
    else if (res_we)           wr_cnt_q <= wr_cnt_q + 1'b1;
  end

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !res_we));

  p_write_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> busy);

  p_write_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> (res_addr == wr_cnt_q[RES_AW-1:0]));

  p_write_total_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (wr_cnt_q == (RES_AW+1)'(TOTAL)));

endmodule

bind gfc_combiner gfc_combiner_sva #(
  .PKT_LEN  (PKT_LEN),
  .CODED_N  (CODED_N),
  .NUM_BATCH(NUM_BATCH)
) u_sva (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .res_we  (res_we),
  .res_addr(res_addr)
);

// File: tb/gfc_combiner_tb.sv
module gfc_combiner_tb;

  localparam int PKT_LEN   = 16;
  localparam int CODED_N   = 4;
  localparam int TILE_K    = 2;
  localparam int NUM_BATCH = 4;
  localparam int NSRC      = 16;
  localparam int TOTAL     = PKT_LEN * CODED_N * NUM_BATCH;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        busy, done;
  logic [1:0]  deg_addr;
  logic [7:0]  deg_data;
  logic [7:0]  idx_addr;
  logic [7:0]  idx_data;
  logic [9:0]  coef_addr;
  logic [7:0]  coef_data;
  logic [11:0] pkt_addr;
  logic [7:0]  pkt_data;
  logic        res_we;
  logic [7:0]  res_addr;
  logic [7:0]  res_data;

  logic [7:0] pkt_mem  [0:255];
  logic [7:0] idx_mem  [0:255];
  logic [7:0] coef_mem [0:1023];
  logic [7:0] deg_mem  [0:3];
  logic [7:0] res_mem  [0:255];
  logic [7:0] exp_mem  [0:255];

  int checks;
  int failures;
  int cyc;
  int wr_count;
  int last_wr;
  int gap4;
  int done_count;
  int done_cyc;
  logic done_busy;

  gfc_combiner u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .deg_addr(deg_addr), .deg_data(deg_data),
    .idx_addr(idx_addr), .idx_data(idx_data),
    .coef_addr(coef_addr), .coef_data(coef_data),
    .pkt_addr(pkt_addr), .pkt_data(pkt_data),
    .res_we(res_we), .res_addr(res_addr), .res_data(res_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Synchronous read memories, one-cycle latency.
  always @(posedge clk) begin
    deg_data  <= deg_mem[deg_addr];
    idx_data  <= idx_mem[idx_addr];
    coef_data <= coef_mem[coef_addr];
    pkt_data  <= pkt_mem[pkt_addr[7:0]];
    cyc       <= cyc + 1;
  end

  // Output monitor, sampled mid-cycle.
  always @(negedge clk) begin
    if (rst_n) begin
      if (res_we) begin
        res_mem[res_addr] = res_data;
        if (wr_count > 0 && cyc - last_wr == 4) gap4++;
        last_wr = cyc;
        wr_count++;
      end
      if (done) begin
        done_count++;
        done_cyc  = cyc;
        done_busy = busy;
      end
    end
  end

  function automatic logic [7:0] gmul(input logic [7:0] x, input logic [7:0] y);
    logic [7:0] r;
    logic [7:0] a;
    logic [7:0] b;
    r = 8'h00;
    a = x;
    b = y;
    for (int i = 0; i < 8; i++) begin
      if (b[0]) r = r ^ a;
      if (a[7]) a = (a << 1) ^ 8'h1D;
      else      a = a << 1;
      b = b >> 1;
    end
    return r;
  endfunction

  task automatic chk(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic model_calc();
    int off;
    off = 0;
    for (int b = 0; b < NUM_BATCH; b++) begin
      int d;
      int t;
      d = int'(deg_mem[b]);
      t = (d / TILE_K) * TILE_K;
      for (int n = 0; n < CODED_N; n++) begin
        for (int m = 0; m < PKT_LEN; m++) begin
          logic [7:0] acc;
          acc = 8'h00;
          for (int k = 0; k < t; k++) begin
            acc ^= gmul(pkt_mem[int'(idx_mem[off + k]) * PKT_LEN + m],
                        coef_mem[(off + k) * CODED_N + n]);
          end
          exp_mem[(b * CODED_N + n) * PKT_LEN + m] = acc;
        end
      end
      off += d;
    end
  endtask

  task automatic fill_random();
    for (int i = 0; i < 256; i++) begin
      pkt_mem[i] = 8'($urandom_range(0, 255));
      idx_mem[i] = 8'($urandom_range(0, NSRC - 1));
    end
    for (int i = 0; i < 1024; i++) coef_mem[i] = 8'($urandom_range(0, 255));
  endtask

  // Runs one job; a second start pulse goes in at cycle extra_at if > 0.
  task automatic run_job(input int extra_at);
    bit seen;
    for (int i = 0; i < 256; i++) res_mem[i] = 8'hEE;
    wr_count   = 0;
    gap4       = 0;
    done_count = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk("R8 busy after start", int'(busy), 1);
    seen = 1'b0;
    for (int i = 0; i < 20000 && !seen; i++) begin
      @(negedge clk);
      start = (extra_at > 0 && i == extra_at);
      if (done_count > 0) seen = 1'b1;
    end
    start = 1'b0;
    if (!seen) chk("R8 done timeout", 0, 1);
    repeat (10) @(negedge clk);
  endtask

  task automatic compare_all(input string req);
    model_calc();
    for (int i = 0; i < TOTAL; i++) chk(req, int'(res_mem[i]), int'(exp_mem[i]));
  endtask

  task automatic t_reset();
    chk("R8 reset busy", int'(busy), 0);
    chk("R8 reset done", int'(done), 0);
    chk("R7 reset res_we", int'(res_we), 0);
  endtask

  task automatic t_known_product();
    for (int i = 0; i < 256; i++) begin
      pkt_mem[i] = 8'h80;
      idx_mem[i] = 8'(i % NSRC);
    end
    for (int i = 0; i < 4; i++) deg_mem[i] = 8'd2;
    for (int t = 0; t < 256; t++)
      for (int n = 0; n < CODED_N; n++)
        coef_mem[t * CODED_N + n] = (t % 2 == 0) ? 8'h02 : 8'h00;
    run_job(0);
    chk("R1 0x80*0x02 first byte", int'(res_mem[0]), 8'h1D);
    chk("R1 0x80*0x02 last byte", int'(res_mem[TOTAL-1]), 8'h1D);
    for (int t = 0; t < 256; t++)
      for (int n = 0; n < CODED_N; n++)
        coef_mem[t * CODED_N + n] = (t % 2 == 0) ? 8'h03 : 8'h00;
    run_job(0);
    chk("R1 0x80*0x03 byte 5", int'(res_mem[5]), 8'h9D);
    chk("R1 0x80*0x03 byte 200", int'(res_mem[200]), 8'h9D);
    compare_all("R1 model");
  endtask

  task automatic t_random_even();
    fill_random();
    for (int i = 0; i < 4; i++) deg_mem[i] = 8'd4;
    run_job(0);
    compare_all("R2 R3 R5 accumulate gather");
    chk("R7 write count", wr_count, TOTAL);
    chk("R10 term-per-clock spacing", gap4, TOTAL - 1 - (NUM_BATCH - 1));
  endtask

  task automatic t_uneven();
    fill_random();
    deg_mem[0] = 8'd3;
    deg_mem[1] = 8'd0;
    deg_mem[2] = 8'd6;
    deg_mem[3] = 8'd1;
    run_job(0);
    compare_all("R4 R6 uneven degrees");
    chk("R6 zero-degree batch", int'(res_mem[1 * 64 + 7]), 0);
    chk("R6 partial-tile batch", int'(res_mem[3 * 64 + 33]), 0);
  endtask

  task automatic t_done_and_restart();
    fill_random();
    for (int i = 0; i < 4; i++) deg_mem[i] = 8'd2;
    run_job(50);
    chk("R9 single done", done_count, 1);
    chk("R9 write count", wr_count, TOTAL);
    chk("R8 done after last write", done_cyc, last_wr + 1);
    chk("R8 busy low at done", int'(done_busy), 0);
    chk("R8 idle after job", int'(busy), 0);
    compare_all("R9 results unchanged");
  endtask

  initial begin
    checks     = 0;
    failures   = 0;
    cyc        = 0;
    wr_count   = 0;
    last_wr    = 0;
    gap4       = 0;
    done_count = 0;
    done_cyc   = 0;
    done_busy  = 1'b0;
    start      = 1'b0;
    rst_n      = 1'b0;
    for (int i = 0; i < 4; i++) deg_mem[i] = 8'd0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_known_product();
    t_random_even();
    t_uneven();
    t_done_and_restart();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL R8 watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule